// File: doc/BRIEF.md
# Rate-Trimmable Seconds/Nanoseconds Time Counter

This block keeps a local time of day as a seconds field and a nanoseconds field. It runs from a fixed input clock. On every clock edge a writable addend is summed into a wrapping accumulator. Each carry out of that accumulator is one time tick, and a tick adds a programmable nanosecond increment to the time. The tick rate is the input frequency times the addend divided by 2^ACC_W. Writing a slightly different addend therefore trims the rate of the local clock in very fine steps.

The control software has two further ways to correct the time. For small errors it changes the rate through the addend. For large errors, such as a second or more, it can add or subtract a signed step in a single cycle, or it can load an absolute time. The current time is driven continuously on output ports for other units to read.

Top module: `adj_time_counter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, time_sec and time_ns are 0. The accumulator and the addend also reset to 0.
- R2: On every clock edge with no load, the stored addend is added to an ACC_W-bit accumulator modulo 2^ACC_W. A carry out of bit ACC_W-1 in that addition is one tick, applied on the same edge.
- R3: A tick adds inc_ns to time_ns. When the sum reaches 1,000,000,000, time_ns wraps to the sum minus 1,000,000,000 and time_sec increments.
- R4: When addend_we is high at an edge, addend_wdata becomes the addend used from the next edge onward. The accumulation on the write edge uses the old addend, and the accumulator is not cleared.
- R5: When load_valid is high at an edge, time_sec and time_ns take load_sec and load_ns and the accumulator clears to 0. No tick is applied on that edge, and load_valid takes priority over step_valid.
- R6: When step_valid is high with step_neg = 0, the step (step_sec, step_ns) is added to the time after any tick of the same edge. A nanosecond carry at 1,000,000,000 goes into seconds, and step_ns must be below 1,000,000,000.
- R7: When step_valid is high with step_neg = 1, the step is subtracted after any tick of the same edge, with a nanosecond borrow from seconds. time_sec wraps modulo 2^SEC_W.
- R8: With an addend of 0 and no load or step, the time does not change.
- R9: time_ns is always below 1,000,000,000, provided load_ns and step_ns are too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_ns | input | INC_W (8) | Nanoseconds added per tick |
| addend_we | input | 1 | Addend write strobe |
| addend_wdata | input | ACC_W (32) | New addend value |
| load_valid | input | 1 | Absolute time load strobe |
| load_sec | input | SEC_W (48) | Seconds to load |
| load_ns | input | 30 | Nanoseconds to load |
| step_valid | input | 1 | Step strobe |
| step_neg | input | 1 | 1 subtracts the step, 0 adds it |
| step_sec | input | SEC_W (48) | Step magnitude, seconds |
| step_ns | input | 30 | Step magnitude, nanoseconds |
| time_sec | output | SEC_W (48) | Current time, seconds |
| time_ns | output | 30 | Current time, nanoseconds |

## Verification
The assertions check several behaviours on every cycle:
- the accumulator advances by exactly the stored addend;
- an addend write lands after one edge;
- a load sets both fields and clears the accumulator;
- a lone tick adds inc_ns with correct wrapping;
- a zero addend freezes the time;
- the nanoseconds field stays in range.

Only the bench scenarios can show the rest:
- that the tick cadence follows the addend over long runs;
- that a rate change keeps the accumulator phase;
- that positive and negative steps carry and borrow correctly, including a seconds wrap below zero;
- that a step combines correctly with a tick on the same edge.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  localparam int unsigned NS_PER_SEC = 1000000000;
  localparam int NS_W = 30;
endpackage

// File: rtl/tc_rate_accum.sv
`timescale 1ns/1ps
module tc_rate_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  output logic             tick,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] addend_q
);
  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] addend_d;

  always_comb begin
    sum_w    = {1'b0, acc_q} + {1'b0, addend_q};
    tick     = sum_w[ACC_W] & ~clr;
    acc_d    = clr ? '0 : sum_w[ACC_W-1:0];
    addend_d = addend_we ? addend_wdata : addend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (addend_we) addend_q <= addend_d;
    end
  end
endmodule

// File: rtl/tc_time_adder.sv
`timescale 1ns/1ps
module tc_time_adder #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input  logic [SEC_W-1:0] a_sec,
  input  logic [NS_W-1:0]  a_ns,
  input  logic [SEC_W-1:0] b_sec,
  input  logic [NS_W-1:0]  b_ns,
  input  logic             sub,
  output logic [SEC_W-1:0] y_sec,
  output logic [NS_W-1:0]  y_ns
);
  localparam logic [NS_W-1:0] BILLION = NS_W'(tc_pkg::NS_PER_SEC);

  logic [NS_W-1:0] headroom;
  logic            wrap;

  always_comb begin
    headroom = BILLION - b_ns;
    if (!sub) begin
      wrap  = (a_ns >= headroom);
      y_ns  = wrap ? (a_ns - headroom) : (a_ns + b_ns);
      y_sec = a_sec + b_sec + {{(SEC_W-1){1'b0}}, wrap};
    end else begin
      wrap  = (a_ns < b_ns);
      y_ns  = wrap ? (a_ns + headroom) : (a_ns - b_ns);
      y_sec = a_sec - b_sec - {{(SEC_W-1){1'b0}}, wrap};
    end
  end
endmodule

// File: rtl/adj_time_counter.sv
`timescale 1ns/1ps
module adj_time_counter #(
  parameter int ACC_W = 32,
  parameter int SEC_W = 48,
  parameter int INC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INC_W-1:0]        inc_ns,
  input  logic                    addend_we,
  input  logic [ACC_W-1:0]        addend_wdata,
  input  logic                    load_valid,
  input  logic [SEC_W-1:0]        load_sec,
  input  logic [tc_pkg::NS_W-1:0] load_ns,
  input  logic                    step_valid,
  input  logic                    step_neg,
  input  logic [SEC_W-1:0]        step_sec,
  input  logic [tc_pkg::NS_W-1:0] step_ns,
  output logic [SEC_W-1:0]        time_sec,
  output logic [tc_pkg::NS_W-1:0] time_ns
);
  localparam int NS_W = tc_pkg::NS_W;

  logic             tick;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] addend_q;
  logic [SEC_W-1:0] tk_sec, st_sec, sec_d;
  logic [NS_W-1:0]  tk_ns, st_ns, ns_d, tk_inc, st_dns;
  logic [SEC_W-1:0] st_dsec;
  logic             time_en;

  tc_rate_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(load_valid),
    .addend_we(addend_we), .addend_wdata(addend_wdata),
    .tick(tick), .acc_q(acc_q), .addend_q(addend_q)
  );

  assign tk_inc  = tick ? NS_W'(inc_ns) : '0;
  assign st_dsec = step_valid ? step_sec : '0;
  assign st_dns  = step_valid ? step_ns : '0;

  tc_time_adder #(.SEC_W(SEC_W), .NS_W(NS_W)) u_tick_add (
    .a_sec(time_sec), .a_ns(time_ns), .b_sec('0), .b_ns(tk_inc),
    .sub(1'b0), .y_sec(tk_sec), .y_ns(tk_ns)
  );

  tc_time_adder #(.SEC_W(SEC_W), .NS_W(NS_W)) u_step_add (
    .a_sec(tk_sec), .a_ns(tk_ns), .b_sec(st_dsec), .b_ns(st_dns),
    .sub(step_neg & step_valid), .y_sec(st_sec), .y_ns(st_ns)
  );

  always_comb begin
    time_en = load_valid | step_valid | tick;
    if (load_valid) begin
      sec_d = load_sec;
      ns_d  = load_ns;
    end else begin
      sec_d = st_sec;
      ns_d  = st_ns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_sec <= '0;
      time_ns  <= '0;
    end else if (time_en) begin
      time_sec <= sec_d;
      time_ns  <= ns_d;
    end
  end
endmodule

// File: rtl/adj_time_counter_chk.sv
`timescale 1ns/1ps
module adj_time_counter_chk #(
  parameter int ACC_W = 32,
  parameter int SEC_W = 48,
  parameter int INC_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [INC_W-1:0]        inc_ns,
  input logic                    addend_we,
  input logic [ACC_W-1:0]        addend_wdata,
  input logic                    load_valid,
  input logic [SEC_W-1:0]        load_sec,
  input logic [tc_pkg::NS_W-1:0] load_ns,
  input logic                    step_valid,
  input logic [SEC_W-1:0]        time_sec,
  input logic [tc_pkg::NS_W-1:0] time_ns,
  input logic                    tick,
  input logic [ACC_W-1:0]        acc_q,
  input logic [ACC_W-1:0]        addend_q
);
  localparam logic [tc_pkg::NS_W:0] BIL = (tc_pkg::NS_W+1)'(tc_pkg::NS_PER_SEC);

  assert_acc_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |=> acc_q == ACC_W'($past(acc_q) + $past(addend_q)));

  assert_tick_ns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_valid && !step_valid) |=>
      (({1'b0, time_ns} == {1'b0, $past(time_ns)} + (tc_pkg::NS_W+1)'($past(inc_ns))) ||
       ({1'b0, time_ns} + BIL == {1'b0, $past(time_ns)} + (tc_pkg::NS_W+1)'($past(inc_ns)))));

  assert_addend_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addend_we |=> addend_q == $past(addend_wdata));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (acc_q == '0) && (time_sec == $past(load_sec)) && (time_ns == $past(load_ns)));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addend_q == '0 && !load_valid && !step_valid) |=> $stable(time_sec) && $stable(time_ns));

  assert_ns_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, time_ns} < BIL);
endmodule

bind adj_time_counter adj_time_counter_chk #(.ACC_W(ACC_W), .SEC_W(SEC_W), .INC_W(INC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_ns(inc_ns), .addend_we(addend_we),
  .addend_wdata(addend_wdata), .load_valid(load_valid), .load_sec(load_sec),
  .load_ns(load_ns), .step_valid(step_valid), .time_sec(time_sec),
  .time_ns(time_ns), .tick(tick), .acc_q(acc_q), .addend_q(addend_q)
);

// File: tb/adj_time_counter_bench.sv
`timescale 1ns/1ps
module adj_time_counter_bench;
  localparam longint BIL  = 64'd1000000000;
  localparam longint SMSK = (64'd1 << 48) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  inc_ns;
  logic        addend_we;
  logic [31:0] addend_wdata;
  logic        load_valid;
  logic [47:0] load_sec;
  logic [29:0] load_ns;
  logic        step_valid, step_neg;
  logic [47:0] step_sec;
  logic [29:0] step_ns;
  logic [47:0] time_sec;
  logic [29:0] time_ns;

  int n_chk = 0;
  int n_bad = 0;
  longint m_sec, m_ns, m_acc, m_add;

  always #4 clk = ~clk;

  adj_time_counter u_adj_time_counter (
    .clk(clk), .rst_n(rst_n), .inc_ns(inc_ns), .addend_we(addend_we),
    .addend_wdata(addend_wdata), .load_valid(load_valid), .load_sec(load_sec),
    .load_ns(load_ns), .step_valid(step_valid), .step_neg(step_neg),
    .step_sec(step_sec), .step_ns(step_ns), .time_sec(time_sec), .time_ns(time_ns)
  );

  task automatic check(string tag);
    n_chk++;
    if (longint'(time_sec) != m_sec || longint'(time_ns) != m_ns) begin
      n_bad++;
      $display("FAIL %s: got %0d s %0d ns, expected %0d s %0d ns",
               tag, time_sec, time_ns, m_sec, m_ns);
    end
  endtask

  // reference model of one edge, derived from R2..R7
  task automatic model(bit awe, longint aw, bit ld, longint ls, longint lns,
                       bit st, bit sn, longint ss, longint sns);
    longint s;
    bit b;
    if (ld) begin
      m_sec = ls & SMSK; m_ns = lns; m_acc = 0;
    end else begin
      s = m_acc + m_add;
      m_acc = s & 64'hFFFF_FFFF;
      if (s > 64'hFFFF_FFFF) begin
        m_ns = m_ns + longint'(inc_ns);
        if (m_ns >= BIL) begin m_ns -= BIL; m_sec = (m_sec + 1) & SMSK; end
      end
      if (st) begin
        if (!sn) begin
          m_ns += sns; b = (m_ns >= BIL);
          if (b) m_ns -= BIL;
          m_sec = (m_sec + ss + longint'(b)) & SMSK;
        end else begin
          b = (m_ns < sns);
          m_ns = b ? m_ns + BIL - sns : m_ns - sns;
          m_sec = (m_sec - ss - longint'(b)) & SMSK;
        end
      end
    end
    if (awe) m_add = aw;
  endtask

  task automatic cyc(string tag, bit awe, longint aw, bit ld, longint ls, longint lns,
                     bit st, bit sn, longint ss, longint sns);
    @(negedge clk);
    addend_we = awe; addend_wdata = 32'(aw);
    load_valid = ld; load_sec = 48'(ls); load_ns = 30'(lns);
    step_valid = st; step_neg = sn; step_sec = 48'(ss); step_ns = 30'(sns);
    model(awe, aw, ld, ls, lns, st, sn, ss, sns);
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; inc_ns = 8'd8; addend_we = 0; addend_wdata = 0;
    load_valid = 0; load_sec = 0; load_ns = 0; step_valid = 0; step_neg = 0;
    step_sec = 0; step_ns = 0;
    m_sec = 0; m_ns = 0; m_acc = 0; m_add = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release");
    idle("R8 zero addend", 4);
    // R4: new addend from next edge, half rate
    cyc("R4 write", 1, 64'h8000_0000, 0, 0, 0, 0, 0, 0, 0);
    idle("R2 half rate", 6);
    cyc("R4 change no clear", 1, 64'h4000_0000, 0, 0, 0, 0, 0, 0, 0);
    idle("R2 quarter rate", 8);
    // R5 load clears accumulator, then R3 rollover
    cyc("R5 load", 1, 64'hFFFF_FFFF, 1, 5, 999999984, 0, 0, 0, 0);
    idle("R3 rollover", 5);
    // R6 positive step with carry
    cyc("R5 load near top", 0, 0, 1, 10, 999999990, 0, 0, 0, 0);
    cyc("R6 step add carry", 0, 0, 0, 0, 0, 1, 0, 1, 999999999);
    // R7 negative step with borrow and seconds wrap
    cyc("R5 load small", 0, 0, 1, 2, 5, 0, 0, 0, 0);
    cyc("R7 step sub wrap", 0, 0, 0, 0, 0, 1, 1, 6, 999999999);
    // R5 load wins over step
    cyc("R5 load over step", 0, 0, 1, 77, 123, 1, 0, 3, 3);
    cyc("R8 freeze setup", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R8 frozen", 4);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit awe, ld, st, sn;
      longint aw, ls, lns, ss, sns;
      r = int'($urandom_range(0, 99));
      awe = (r < 10); ld = (r >= 10 && r < 12); st = (r >= 12 && r < 18);
      sn = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 3))
        0: aw = 64'hFFFF_FFFF;
        1: aw = 0;
        default: aw = longint'($urandom);
      endcase
      ls = (longint'($urandom) << 16) ^ longint'($urandom);
      lns = longint'($urandom_range(0, 999999999));
      ss = ($urandom_range(0, 3) == 0) ? ((longint'($urandom) << 16) ^ longint'($urandom))
                                       : longint'($urandom_range(0, 3));
      sns = ($urandom_range(0, 3) == 0) ? 999999999 : longint'($urandom_range(0, 999999999));
      if ($urandom_range(0, 49) == 0) inc_ns = 8'($urandom_range(1, 255));
      cyc("R2 R3 R6 R7 random", awe, aw, ld, ls, lns, st, sn, ss, sns);
    end
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule